// File: doc/BRIEF.md
# Interrupt Enable and Horizontal Sync Selector

This block sits between a processor's I/O write path and the video sync output of a small home-computer display system. Two I/O port writes control a single interrupt-enable flag. One port sets it and one clears it. While the flag is in force, the line sync reaching the video output comes from a free-running hardware generator. While it is off, the sync comes from pulses that software triggers. Each source is blocked completely while the other one is selected.

Turning the flag off makes the software sync path emit one stray pulse. To hide it, the block keeps the selection on the hardware source for a fixed number of clock cycles after each clearing write. The same effective enable also blocks resets of the character line counter, so that program activity during hardware-timed lines cannot disturb the row count. A separate combinational term pulls the processor's wait line low when an interrupt is pending and the processor is not halted. This realigns execution to a known point.

Top module: `sync_sel_ctrl`

## Requirements
- R1: At a rising clock edge where `io_wr_n` is low and `addr_a0` is low, the enable is set from the next cycle on, whatever the value of `addr_a1`.
- R2: At a rising edge where `io_wr_n` is low, `addr_a0` is high and `addr_a1` is low, the enable is cleared. A write with both address bits high, and any edge with `io_wr_n` high, leaves the enable unchanged.
- R3: After a clearing write edge, the effective enable stays asserted for exactly STRETCH_CYCLES (default 24) further cycles and then drops. A new clearing write restarts this count.
- R4: A setting write that arrives during the stretch keeps the effective enable asserted with no expiry.
- R5: While the effective enable is asserted, `mix_sync` equals `hw_sync`, and `sw_sync` has no effect on it. This includes the stray software pulse that occurs during the stretch.
- R6: While the effective enable is deasserted, `mix_sync` equals `sw_sync`, and `hw_sync` has no effect on it.
- R7: `line_rst_dis` is high exactly while the effective enable (set flag or running stretch) is asserted.
- R8: `wait_n` is low, in the same cycle and without a clock edge, exactly when `halt_n` is high and `irq_n` is low.
- R9: A synchronous active-high `rst` clears both the enable and the stretch. After reset, `line_rst_dis` is low and `mix_sync` follows `sw_sync`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr_n | input | 1 | I/O write strobe, active low |
| addr_a0 | input | 1 | Address bit 0 of the I/O cycle |
| addr_a1 | input | 1 | Address bit 1 of the I/O cycle |
| sw_sync | input | 1 | Software-triggered line sync, high = sync |
| hw_sync | input | 1 | Free-running hardware line sync, high = sync |
| irq_n | input | 1 | Non-maskable interrupt line, active low |
| halt_n | input | 1 | Processor halt status, active low |
| mix_sync | output | 1 | Selected line sync to the video output |
| line_rst_dis | output | 1 | Blocks character line-counter reset when high |
| wait_n | output | 1 | Wait request to the processor, active low |

## Verification
The enable and stretch results are registered. A port write captured at one rising edge shows on `line_rst_dis` and on the sync selection at the following falling edge. The stretch boundary is therefore probed at the falling edge after the 24th edge that follows the write edge. The sync mix and the wait request are combinational. The bench changes their inputs at a falling edge and samples 2 ns later, inside the same low phase. Every port write is driven for exactly one rising edge, so the edge that captures each command is known when the expected values are counted.

// File: rtl/sync_sel_pkg.sv
package sync_sel_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_SET  = 2'd1,
    CMD_CLR  = 2'd2
  } en_cmd_e;

  // Setting port: address bit 0 low, bit 1 is don't-care.
  function automatic logic hit_set_port(input logic a0);
    return !a0;
  endfunction

  // Clearing port: bit 0 high, bit 1 low.
  function automatic logic hit_clr_port(input logic a0, input logic a1);
    return a0 && !a1;
  endfunction

  // Wait request (active low): running CPU with a pending interrupt.
  function automatic logic calc_wait_n(input logic halt_n, input logic irq_n);
    return !(halt_n && !irq_n);
  endfunction

  // Next value of the turn-off stretch counter.
  function automatic int unsigned stretch_next(input int unsigned cur,
                                               input en_cmd_e cmd,
                                               input int unsigned len);
    if (cmd == CMD_CLR) return len;
    if (cmd == CMD_SET) return 0;
    if (cur != 0)       return cur - 1;
    return 0;
  endfunction

endpackage

// File: rtl/sync_sel_decode.sv
module sync_sel_decode
  import sync_sel_pkg::*;
(
  input  logic    io_wr_n,
  input  logic    addr_a0,
  input  logic    addr_a1,
  output logic    set_hit,
  output logic    clr_hit,
  output en_cmd_e cmd
);

  always_comb begin
    set_hit = !io_wr_n && hit_set_port(addr_a0);
    clr_hit = !io_wr_n && hit_clr_port(addr_a0, addr_a1);
    if (set_hit)      cmd = CMD_SET;
    else if (clr_hit) cmd = CMD_CLR;
    else              cmd = CMD_NONE;
  end

endmodule

// File: rtl/sync_sel_enable.sv
module sync_sel_enable
  import sync_sel_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = 24
) (
  input  logic    clk,
  input  logic    rst,
  input  en_cmd_e cmd,
  output logic    en_q,
  output logic    stretch_busy,
  output logic    eff_en
);

  localparam int unsigned CNT_W = $clog2(STRETCH_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = CNT_W'(stretch_next(int'(cnt_q), cmd, STRETCH_CYCLES));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (cmd == CMD_SET)      en_q <= 1'b1;
      else if (cmd == CMD_CLR) en_q <= 1'b0;
    end
  end

  assign stretch_busy = (cnt_q != '0);
  assign eff_en       = en_q || stretch_busy;

endmodule

// File: rtl/sync_sel_mux.sv
module sync_sel_mux
  import sync_sel_pkg::*;
(
  input  logic eff_en,
  input  logic sw_sync,
  input  logic hw_sync,
  input  logic irq_n,
  input  logic halt_n,
  output logic mix_sync,
  output logic line_rst_dis,
  output logic wait_n
);

  logic hw_gated;
  logic sw_gated;

  always_comb begin
    hw_gated     = hw_sync && eff_en;
    sw_gated     = sw_sync && !eff_en;
    mix_sync     = hw_gated || sw_gated;
    line_rst_dis = eff_en;
    wait_n       = calc_wait_n(halt_n, irq_n);
  end

endmodule

// File: rtl/sync_sel_ctrl.sv
module sync_sel_ctrl
  import sync_sel_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic io_wr_n,
  input  logic addr_a0,
  input  logic addr_a1,
  input  logic sw_sync,
  input  logic hw_sync,
  input  logic irq_n,
  input  logic halt_n,
  output logic mix_sync,
  output logic line_rst_dis,
  output logic wait_n
);

  en_cmd_e cmd;
  logic    set_hit;
  logic    clr_hit;
  logic    en_q;
  logic    stretch_busy;
  logic    eff_en;

  sync_sel_decode u_decode (
    .io_wr_n (io_wr_n),
    .addr_a0 (addr_a0),
    .addr_a1 (addr_a1),
    .set_hit (set_hit),
    .clr_hit (clr_hit),
    .cmd     (cmd)
  );

  sync_sel_enable #(
    .STRETCH_CYCLES (STRETCH_CYCLES)
  ) u_enable (
    .clk          (clk),
    .rst          (rst),
    .cmd          (cmd),
    .en_q         (en_q),
    .stretch_busy (stretch_busy),
    .eff_en       (eff_en)
  );

  sync_sel_mux u_mux (
    .eff_en       (eff_en),
    .sw_sync      (sw_sync),
    .hw_sync      (hw_sync),
    .irq_n        (irq_n),
    .halt_n       (halt_n),
    .mix_sync     (mix_sync),
    .line_rst_dis (line_rst_dis),
    .wait_n       (wait_n)
  );

endmodule

// File: rtl/sync_sel_ctrl_chk.sv
module sync_sel_ctrl_chk #(
  parameter int unsigned STRETCH_CYCLES = 24
) (
  input logic clk,
  input logic rst,
  input logic io_wr_n,
  input logic addr_a0,
  input logic addr_a1,
  input logic sw_sync,
  input logic hw_sync,
  input logic irq_n,
  input logic halt_n,
  input logic mix_sync,
  input logic line_rst_dis,
  input logic wait_n,
  input logic set_hit,
  input logic clr_hit,
  input logic en_q,
  input logic stretch_busy
);

  // Independent window model, counted from port activity.
  logic        mdl_en;
  int unsigned mdl_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdl_en  <= 1'b0;
      mdl_cnt <= 0;
    end else if (!io_wr_n && !addr_a0) begin
      mdl_en  <= 1'b1;
      mdl_cnt <= 0;
    end else if (!io_wr_n && !addr_a1) begin
      mdl_en  <= 1'b0;
      mdl_cnt <= STRETCH_CYCLES;
    end else if (mdl_cnt != 0) begin
      mdl_cnt <= mdl_cnt - 1;
    end
  end

  p_set_r1: assert property (@(posedge clk) disable iff (rst)
    (!io_wr_n && !addr_a0) |=> (en_q && line_rst_dis));

  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (!io_wr_n && addr_a0 && !addr_a1) |=> (!en_q && stretch_busy));

  p_dec_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({set_hit, clr_hit}));

  p_stretch_r3: assert property (@(posedge clk) disable iff (rst)
    line_rst_dis == (mdl_en || (mdl_cnt != 0)));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (line_rst_dis && io_wr_n && en_q) |=> line_rst_dis);

  p_hw_pass_r5: assert property (@(posedge clk) disable iff (rst)
    line_rst_dis |-> (mix_sync == hw_sync));

  p_sw_pass_r6: assert property (@(posedge clk) disable iff (rst)
    !line_rst_dis |-> (mix_sync == sw_sync));

  p_wait_low_r8: assert property (@(posedge clk) disable iff (rst)
    !wait_n |-> (halt_n && !irq_n));

  p_wait_high_r8: assert property (@(posedge clk) disable iff (rst)
    (halt_n && !irq_n) |-> !wait_n);

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!line_rst_dis && !en_q));

endmodule

bind sync_sel_ctrl sync_sel_ctrl_chk #(
  .STRETCH_CYCLES (STRETCH_CYCLES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .io_wr_n      (io_wr_n),
  .addr_a0      (addr_a0),
  .addr_a1      (addr_a1),
  .sw_sync      (sw_sync),
  .hw_sync      (hw_sync),
  .irq_n        (irq_n),
  .halt_n       (halt_n),
  .mix_sync     (mix_sync),
  .line_rst_dis (line_rst_dis),
  .wait_n       (wait_n),
  .set_hit      (set_hit),
  .clr_hit      (clr_hit),
  .en_q         (en_q),
  .stretch_busy (stretch_busy)
);

// File: tb/tb_sync_sel_ctrl.sv
`timescale 1ns/1ps
module tb_sync_sel_ctrl;

  localparam int STRETCH = 24;

  logic clk = 1'b0;
  logic rst, io_wr_n, addr_a0, addr_a1, sw_sync, hw_sync, irq_n, halt_n;
  logic mix_sync, line_rst_dis, wait_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  sync_sel_ctrl #(.STRETCH_CYCLES(STRETCH)) dut (
    .clk (clk), .rst (rst), .io_wr_n (io_wr_n),
    .addr_a0 (addr_a0), .addr_a1 (addr_a1),
    .sw_sync (sw_sync), .hw_sync (hw_sync),
    .irq_n (irq_n), .halt_n (halt_n),
    .mix_sync (mix_sync), .line_rst_dis (line_rst_dis), .wait_n (wait_n)
  );

  // Vector: {mode, sw, hw, irq_n, halt_n, exp_mix, exp_wait}
  localparam int NV = 12;
  localparam logic [6:0] VEC [NV] = '{
    7'b0_1_0_1_1_1_1,   // off: software sync passes            (R6)
    7'b0_0_1_1_1_0_1,   // off: hardware sync blocked           (R6)
    7'b0_1_1_0_1_1_0,   // off: both, irq pending, running      (R6,R8)
    7'b0_0_0_0_0_0_1,   // off: halted, no wait                 (R8)
    7'b1_0_1_1_1_1_1,   // on: hardware sync passes             (R5)
    7'b1_1_0_1_1_0_1,   // on: software sync blocked            (R5)
    7'b1_1_1_0_1_1_0,   // on: irq pending, running -> wait     (R5,R8)
    7'b1_0_0_1_0_0_1,   // on: halted, no irq                   (R8)
    7'b1_0_0_0_0_0_1,   // on: halted with irq, no wait         (R8)
    7'b0_0_0_1_1_0_1,   // off: idle                            (R6)
    7'b0_1_0_0_1_1_0,   // off: irq running -> wait             (R8)
    7'b1_0_1_0_0_1_1    // on: halted with irq                  (R5,R8)
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic a0, input logic a1);
    @(negedge clk);
    io_wr_n = 1'b0; addr_a0 = a0; addr_a1 = a1;
    @(negedge clk);
    io_wr_n = 1'b1; addr_a0 = 1'b1; addr_a1 = 1'b1;
  endtask

  task automatic set_mode(input logic on);
    if (on) do_write(1'b0, 1'b1);
    else begin
      do_write(1'b1, 1'b0);
      repeat (STRETCH + 2) @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic cur_mode;
    rst = 1'b1; io_wr_n = 1'b1; addr_a0 = 1'b1; addr_a1 = 1'b1;
    sw_sync = 1'b0; hw_sync = 1'b0; irq_n = 1'b1; halt_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset dis", line_rst_dis, 1'b0);
    sw_sync = 1'b1; #2;
    check("R9 reset mix follows sw", mix_sync, 1'b1);
    @(negedge clk);
    sw_sync = 1'b0; hw_sync = 1'b1; #2;
    check("R9 reset hw blocked", mix_sync, 1'b0);
    @(negedge clk);
    rst = 1'b0; hw_sync = 1'b0;
    cur_mode = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][6] != cur_mode) begin
        set_mode(VEC[i][6]);
        cur_mode = VEC[i][6];
      end
      @(negedge clk);
      sw_sync = VEC[i][5]; hw_sync = VEC[i][4];
      irq_n = VEC[i][3];   halt_n = VEC[i][2];
      #2;
      check(VEC[i][6] ? "R5 mix on" : "R6 mix off", mix_sync, VEC[i][1]);
      check("R8 wait", wait_n, VEC[i][0]);
      check("R7 dis follows mode", line_rst_dis, VEC[i][6]);
    end
    sw_sync = 1'b0; hw_sync = 1'b0; irq_n = 1'b1; halt_n = 1'b1;

    // R2: strobe high with set address does nothing
    set_mode(1'b0);
    @(negedge clk); addr_a0 = 1'b0; addr_a1 = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 no strobe no set", line_rst_dis, 1'b0);
    addr_a0 = 1'b1;

    // R1: both address bits low sets
    do_write(1'b0, 1'b0);
    check("R1 set a1 low", line_rst_dis, 1'b1);
    repeat (STRETCH + 6) @(negedge clk);
    check("R1 set persists", line_rst_dis, 1'b1);

    // R2: write to neither port leaves enable set
    do_write(1'b1, 1'b1);
    repeat (STRETCH + 6) @(negedge clk);
    check("R2 other port ignored", line_rst_dis, 1'b1);

    // R3/R5: exact stretch, stray software pulse masked
    do_write(1'b1, 1'b0);
    sw_sync = 1'b1; hw_sync = 1'b0; #2;
    check("R3 stretch start", line_rst_dis, 1'b1);
    check("R5 stray pulse masked", mix_sync, 1'b0);
    for (int k = 1; k < STRETCH; k++) begin
      @(negedge clk); #2;
      check("R3 stretch held", line_rst_dis, 1'b1);
      check("R5 stray masked", mix_sync, 1'b0);
    end
    @(negedge clk); #2;
    check("R3 stretch end", line_rst_dis, 1'b0);
    check("R6 sw after stretch", mix_sync, 1'b1);
    sw_sync = 1'b0;

    // R3: retrigger from a second clearing write
    set_mode(1'b1);
    do_write(1'b1, 1'b0);
    repeat (9) @(negedge clk);
    do_write(1'b1, 1'b0);
    for (int k = 1; k < STRETCH; k++) begin
      @(negedge clk);
      check("R3 retrigger held", line_rst_dis, 1'b1);
    end
    @(negedge clk);
    check("R3 retrigger end", line_rst_dis, 1'b0);

    // R4: set during stretch cancels expiry
    set_mode(1'b1);
    do_write(1'b1, 1'b0);
    repeat (5) @(negedge clk);
    do_write(1'b0, 1'b1);
    repeat (STRETCH + 16) @(negedge clk);
    check("R4 set in stretch holds", line_rst_dis, 1'b1);
    hw_sync = 1'b1; #2;
    check("R5 hw passes after R4", mix_sync, 1'b1);
    hw_sync = 1'b0;

    // R9: reset while enabled
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R9 reset clears enable", line_rst_dis, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 stays cleared", line_rst_dis, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule